// File: doc/BRIEF.md
# Transmit Buffer Priority Selector

This block chooses which of three transmit message buffers a CAN-style controller sends next. Each buffer carries an 8-bit local priority, a data length code, eight data byte registers and an empty flag. A host loads buffers through a simple register-write port. It then hands a buffer over for sending by writing that buffer's submit register, which clears its empty flag and marks it pending.

When the frame engine is about to issue a start-of-frame, it pulses `sof_request`. At that instant the block compares the pending buffers and latches a winner. The lowest numeric priority wins, and the lower index wins a tie. The winner's index and a valid flag are then held for the whole frame. Its data bytes leave on a valid/ready byte stream. A byte moves on every cycle where `byte_valid` and `byte_ready` are both high. While `byte_ready` is low, the current byte and `byte_valid` stay put. The stream carries as many bytes as the length code asks for, with a ceiling of eight. A one-cycle `tx_done` pulse ends the frame, sets the winner's empty flag again and reopens its registers for writing.

Top module: `tx_prio_sel`

## Requirements
- R1: After reset every empty flag is 1, every priority and length code is 0, and `sel_valid` and `byte_valid` are 0.
- R2: On `sof_request` with `sel_valid` low, the pending buffer with the smallest priority value is latched: `sel_valid` goes to 1 and `sel_idx` gives its index on the next cycle.
- R3: When several pending buffers share the smallest priority value, the one with the lowest index is chosen.
- R4: Buffers whose empty flag is 1 take no part in the choice. If none is pending at `sof_request`, `sel_valid` stays 0.
- R5: Once latched, `sel_idx` and `sel_valid` hold until `tx_done`. A further `sof_request` or a newly submitted buffer changes nothing.
- R6: After latching, the stream delivers data bytes 0 up to len-1 of the winner in order, where len is the clamped length code. `byte_last` is 1 on the final byte. A length of 0 gives no byte.
- R7: A length code above 8 streams exactly 8 bytes.
- R8: While a buffer's empty flag is 0, every write to that buffer is ignored. This covers data, length, priority and submit writes.
- R9: A `tx_done` pulse while `sel_valid` is 1 sets the winner's empty flag and drops `sel_valid` on the next cycle.
- R10: The register map per buffer is as follows. `wr_addr` 0 to 7 selects data byte 0 to 7. Address 8 is the length code, taken from `wr_data[3:0]`. Address 9 is the priority. Address 10 is submit. A submit write to an empty buffer clears its empty flag.
- R11: While `byte_valid` is 1 and `byte_ready` is 0, `byte_valid` stays 1 and `byte_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_buf | input | IDX_W | Buffer addressed by the write |
| wr_addr | input | 4 | Register within the buffer |
| wr_data | input | DATA_W | Write data |
| sof_request | input | 1 | Start-of-frame strobe; latches the winner |
| tx_done | input | 1 | Frame finished; releases the winner |
| sel_valid | output | 1 | A winner is latched |
| sel_idx | output | IDX_W | Index of the latched winner |
| buf_empty | output | NUM_BUF | Per-buffer empty flags |
| byte_valid | output | 1 | Stream byte available |
| byte_ready | input | 1 | Sink accepts the byte |
| byte_data | output | DATA_W | Stream byte |
| byte_last | output | 1 | Final byte of the frame |

## Verification
The bench uses the default build: three buffers, 8-bit priorities and eight data bytes. At that size the whole space of pending masks, crossed with every arrangement of three priority levels, can be swept. Every case is drained one frame at a time, so each winner, each tie-break and the final empty-state request are predicted arithmetically. Length codes rotate through 0 to 10, which brings both the zero-length case and the clamp into every sweep. Each pending buffer is also attacked with overwrites whose effect would show in the streamed bytes.

// File: rtl/tx_prio_pkg.sv
package tx_prio_pkg;
  localparam int REG_ADDR_W = 4;
  localparam logic [REG_ADDR_W-1:0] REG_LEN    = 4'd8;
  localparam logic [REG_ADDR_W-1:0] REG_PRIO   = 4'd9;
  localparam logic [REG_ADDR_W-1:0] REG_SUBMIT = 4'd10;
endpackage

// File: rtl/tx_buf_bank.sv
module tx_buf_bank
  import tx_prio_pkg::*;
#(
  parameter int NUM_BUF   = 3,
  parameter int PRIO_W    = 8,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4,
  parameter int IDX_W     = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [IDX_W-1:0]                     wr_buf,
  input  logic [REG_ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic [NUM_BUF-1:0]                   release_vec,
  output logic [NUM_BUF-1:0]                   empty_o,
  output logic [NUM_BUF*PRIO_W-1:0]            prio_o,
  output logic [NUM_BUF*LEN_W-1:0]             len_o,
  output logic [NUM_BUF*MAX_BYTES*DATA_W-1:0]  data_o
);
  localparam int BUF_BITS = MAX_BYTES * DATA_W;

  for (genvar gb = 0; gb < NUM_BUF; gb++) begin : g_buf
    logic                               emp_q;
    logic [PRIO_W-1:0]                  prio_q;
    logic [LEN_W-1:0]                   len_q;
    logic [MAX_BYTES-1:0][DATA_W-1:0]   data_q;
    logic                               hit;

    // writes reach this buffer only while it is empty
    assign hit = wr_en && (wr_buf == IDX_W'(gb)) && emp_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        emp_q  <= 1'b1;
        prio_q <= '0;
        len_q  <= '0;
        data_q <= '0;
      end else begin
        if (release_vec[gb])
          emp_q <= 1'b1;
        else if (hit && wr_addr == REG_SUBMIT)
          emp_q <= 1'b0;
        if (hit && wr_addr == REG_PRIO)
          prio_q <= wr_data[PRIO_W-1:0];
        if (hit && wr_addr == REG_LEN)
          len_q <= wr_data[LEN_W-1:0];
        for (int j = 0; j < MAX_BYTES; j++)
          if (hit && wr_addr == REG_ADDR_W'(j))
            data_q[j] <= wr_data;
      end
    end

    assign empty_o[gb]                        = emp_q;
    assign prio_o[gb*PRIO_W +: PRIO_W]        = prio_q;
    assign len_o[gb*LEN_W +: LEN_W]           = len_q;
    assign data_o[gb*BUF_BITS +: BUF_BITS]    = data_q;
  end
endmodule

// File: rtl/tx_prio_arb.sv
module tx_prio_arb #(
  parameter int NUM_BUF = 3,
  parameter int PRIO_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_BUF-1:0]        pend,
  input  logic [NUM_BUF*PRIO_W-1:0] prio,
  output logic                      win_valid,
  output logic [IDX_W-1:0]          win_idx
);
  logic [PRIO_W-1:0] best;

  // strict less-than keeps the earlier (lower) index on equal values
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best      = '1;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (pend[i] && (!win_valid || prio[i*PRIO_W +: PRIO_W] < best)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        best      = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/tx_byte_stream.sv
module tx_byte_stream #(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8,
  parameter int CNT_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        stop,
  input  logic [CNT_W-1:0]            len_in,
  input  logic [MAX_BYTES*DATA_W-1:0] bytes_in,
  output logic                        byte_valid,
  input  logic                        byte_ready,
  output logic [DATA_W-1:0]           byte_data,
  output logic                        byte_last
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
    end else if (stop) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      len_q    <= len_in;
    end else if (byte_valid && byte_ready) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pick       = (cnt_q < CNT_W'(MAX_BYTES)) ? cnt_q : '0;
  assign byte_valid = active_q && (cnt_q < len_q);
  assign byte_last  = byte_valid && (cnt_q == len_q - 1'b1);
  assign byte_data  = bytes_in[pick*DATA_W +: DATA_W];
endmodule

// File: rtl/tx_prio_sel.sv
module tx_prio_sel
  import tx_prio_pkg::*;
#(
  parameter int NUM_BUF   = 3,
  parameter int PRIO_W    = 8,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4,
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_buf,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  sof_request,
  input  logic                  tx_done,
  output logic                  sel_valid,
  output logic [IDX_W-1:0]      sel_idx,
  output logic [NUM_BUF-1:0]    buf_empty,
  output logic                  byte_valid,
  input  logic                  byte_ready,
  output logic [DATA_W-1:0]     byte_data,
  output logic                  byte_last
);
  localparam int BUF_BITS = MAX_BYTES * DATA_W;
  localparam int CNT_W    = $clog2(MAX_BYTES + 1);

  logic [NUM_BUF-1:0]          empty_w;
  logic [NUM_BUF*PRIO_W-1:0]   prio_w;
  logic [NUM_BUF*LEN_W-1:0]    len_w;
  logic [NUM_BUF*BUF_BITS-1:0] data_w;
  logic [NUM_BUF-1:0]          release_vec;
  logic                        win_valid;
  logic [IDX_W-1:0]            win_idx;
  logic                        start;
  logic                        stop;
  logic [LEN_W-1:0]            win_len;
  logic [CNT_W-1:0]            win_len_clamped;
  logic                        sel_valid_q;
  logic [IDX_W-1:0]            sel_idx_q;

  tx_buf_bank #(
    .NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_addr(wr_addr), .wr_data(wr_data), .release_vec(release_vec),
    .empty_o(empty_w), .prio_o(prio_w), .len_o(len_w), .data_o(data_w)
  );

  tx_prio_arb #(
    .NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) arb_i (
    .pend(~empty_w), .prio(prio_w), .win_valid(win_valid), .win_idx(win_idx)
  );

  // a frame's choice is taken only when nothing is latched
  assign start = sof_request && !sel_valid_q && win_valid;
  assign stop  = tx_done && sel_valid_q;

  assign win_len         = len_w[win_idx*LEN_W +: LEN_W];
  assign win_len_clamped = (32'(win_len) > MAX_BYTES) ? CNT_W'(MAX_BYTES)
                                                      : CNT_W'(win_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid_q <= 1'b0;
      sel_idx_q   <= '0;
    end else if (stop) begin
      sel_valid_q <= 1'b0;
    end else if (start) begin
      sel_valid_q <= 1'b1;
      sel_idx_q   <= win_idx;
    end
  end

  always_comb begin
    release_vec = '0;
    if (stop) release_vec[sel_idx_q] = 1'b1;
  end

  tx_byte_stream #(
    .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
  ) strm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .len_in(win_len_clamped),
    .bytes_in(data_w[sel_idx_q*BUF_BITS +: BUF_BITS]),
    .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .byte_last(byte_last)
  );

  assign sel_valid = sel_valid_q;
  assign sel_idx   = sel_idx_q;
  assign buf_empty = empty_w;
endmodule

// File: rtl/tx_prio_sel_chk.sv
module tx_prio_sel_chk #(
  parameter int NUM_BUF = 3,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sof_request,
  input logic               tx_done,
  input logic               sel_valid,
  input logic [IDX_W-1:0]   sel_idx,
  input logic [NUM_BUF-1:0] buf_empty,
  input logic               byte_valid,
  input logic               byte_ready,
  input logic [DATA_W-1:0]  byte_data
);
  // R5
  frozen_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && !tx_done |=> sel_valid && $stable(sel_idx));

  // R4
  none_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_request && !sel_valid && (&buf_empty) |=> !sel_valid);

  // R2
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> !buf_empty[sel_idx]);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && sel_valid |=> !sel_valid && buf_empty[$past(sel_idx)]);

  // R6
  stream_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> sel_valid);

  // R11
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready && !tx_done |=> byte_valid && $stable(byte_data));
endmodule

bind tx_prio_sel tx_prio_sel_chk #(
  .NUM_BUF(NUM_BUF), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sof_request(sof_request), .tx_done(tx_done),
  .sel_valid(sel_valid), .sel_idx(sel_idx), .buf_empty(buf_empty),
  .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data)
);

// File: tb/tx_prio_sel_tb_top.sv
module tx_prio_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_buf = '0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sof_request = 1'b0;
  logic       tx_done = 1'b0;
  logic       byte_ready = 1'b1;
  logic       sel_valid;
  logic [1:0] sel_idx;
  logic [2:0] buf_empty;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_last;

  int total = 0;
  int bad = 0;

  logic [7:0] e_data [3][8];
  logic [3:0] e_len  [3];
  logic [7:0] e_prio [3];

  always #10 clk = ~clk;

  tx_prio_sel dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_addr(wr_addr), .wr_data(wr_data), .sof_request(sof_request),
    .tx_done(tx_done), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .buf_empty(buf_empty), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .byte_last(byte_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int b, input int a, input int d);
    wr_en = 1'b1; wr_buf = 2'(b); wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int b, input int len, input int prio, input int seed);
    for (int j = 0; j < 8; j++) begin
      e_data[b][j] = 8'(seed + b * 16 + j * 3);
      wr(b, j, e_data[b][j]);
    end
    e_len[b] = 4'(len);   wr(b, 8, len);
    e_prio[b] = 8'(prio); wr(b, 9, prio);
  endtask

  task automatic sof();
    sof_request = 1'b1;
    @(negedge clk);
    sof_request = 1'b0;
  endtask

  task automatic finish_frame(input int b);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk(buf_empty[b] == 1'b1, "R9 winner empty after done", int'(buf_empty[b]), 1);
    chk(sel_valid == 1'b0, "R9 valid low after done", int'(sel_valid), 0);
  endtask

  // checks the stream of buffer b with ready held high
  task automatic drain_stream(input int b);
    int n;
    n = (e_len[b] > 8) ? 8 : int'(e_len[b]);
    for (int k = 0; k < n; k++) begin
      chk(byte_valid == 1'b1, (e_len[b] > 8) ? "R7 byte valid" : "R6 byte valid",
          int'(byte_valid), 1);
      chk(byte_data == e_data[b][k], "R6/R8 byte value", int'(byte_data), int'(e_data[b][k]));
      chk(byte_last == (k == n - 1), "R6 last flag", int'(byte_last), int'(k == n - 1));
      @(negedge clk);
    end
    chk(byte_valid == 1'b0, (e_len[b] > 8) ? "R7 clamp to 8" : "R6 stream ends",
        int'(byte_valid), 0);
  endtask

  task automatic run_all();
    int exp_w;
    int rem;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(buf_empty == 3'b111, "R1 empty flags", int'(buf_empty), 7);
    chk(sel_valid == 1'b0, "R1 valid low", int'(sel_valid), 0);
    chk(byte_valid == 1'b0, "R1 stream idle", int'(byte_valid), 0);
    // R1 priorities and lengths at 0: all tie -> index 0, no bytes
    for (int b = 0; b < 3; b++) wr(b, 10, 0);
    // R10 submit clears empty flags
    chk(buf_empty == 3'b000, "R10 submit", int'(buf_empty), 0);
    for (int r = 0; r < 3; r++) begin
      sof();
      chk(sel_valid && sel_idx == 2'(r), "R1 zero prio tie order", int'(sel_idx), r);
      chk(byte_valid == 1'b0, "R1 zero length", int'(byte_valid), 0);
      finish_frame(r);
    end

    // R5 choice frozen until done
    load(1, 0, 5, 0); wr(1, 10, 0);
    sof();
    chk(sel_valid && sel_idx == 2'd1, "R5 first choice", int'(sel_idx), 1);
    load(0, 0, 0, 0); wr(0, 10, 0);
    sof();
    chk(sel_valid && sel_idx == 2'd1, "R5 held despite better buffer", int'(sel_idx), 1);
    finish_frame(1);
    sof();
    chk(sel_valid && sel_idx == 2'd0, "R5 next frame picks it", int'(sel_idx), 0);
    finish_frame(0);

    // R11 back-pressure
    load(2, 3, 255, 8'hA0); wr(2, 10, 0);
    sof();
    byte_ready = 1'b0;
    for (int t = 0; t < 3; t++) begin
      chk(byte_valid == 1'b1, "R11 valid held", int'(byte_valid), 1);
      chk(byte_data == e_data[2][0], "R11 data held", int'(byte_data), int'(e_data[2][0]));
      @(negedge clk);
    end
    byte_ready = 1'b1;
    drain_stream(2);
    finish_frame(2);

    // R2 R3 R4 R7 R8 sweep: pending masks x priority levels
    for (int m = 0; m < 8; m++) begin
      for (int pc = 0; pc < 27; pc++) begin
        int pr [3];
        int seed;
        pr[0] = pc % 3; pr[1] = (pc / 3) % 3; pr[2] = pc / 9;
        seed = m * 27 + pc;
        for (int b = 0; b < 3; b++) load(b, (seed + b * 3) % 11, pr[b], seed);
        for (int b = 0; b < 3; b++) if (m[b]) wr(b, 10, 0);
        // R8 overwrite attempts on pending buffers
        for (int b = 0; b < 3; b++) if (m[b]) begin
          wr(b, 9, 255); wr(b, 0, 8'hEE); wr(b, 8, 0);
        end
        chk(buf_empty == 3'(~m), "R10 pending mask", int'(buf_empty), int'(3'(~m)));
        rem = m;
        while (rem != 0) begin
          exp_w = -1;
          for (int b = 0; b < 3; b++)
            if (rem[b] && (exp_w < 0 || e_prio[b] < e_prio[exp_w])) exp_w = b;
          sof();
          chk(sel_valid && sel_idx == 2'(exp_w), "R2/R3 winner", int'(sel_idx), exp_w);
          drain_stream(exp_w);
          finish_frame(exp_w);
          rem = rem & ~(1 << exp_w);
        end
        sof();
        // R4 nothing pending
        chk(sel_valid == 1'b0, "R4 none pending", int'(sel_valid), 0);
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule